// File: doc/BRIEF.md
# Platform Sleep-State Sequencer

This block steps a small computer platform between the working state (S0), suspend-to-memory (S3), suspend-to-disk (S4) and soft-off (S5). It reads a debounced active-low power button, a thermal-trip input and four rail-good inputs: always-on, management island, memory and run. From these it drives active-low sleep lines for S3, S4 and S5, sleep lines for the management and network islands, a suspend-status line, a processor power-good, a run-rail enable and a platform reset.

Internally the platform is tracked as a single level, from 0 to 8. The level is the number of lines asserted from a fixed ordered list: platform reset, suspend status, processor power-good, S3, management, network, S4, then S5. Going down asserts one more line per cycle. Going up releases lines in reverse order, and some steps wait on rail-good inputs. Three events force soft-off:
- a long button hold;
- a thermal trip while processor power-good is high;
- a rail loss in S0.

The first such cause is kept in a sticky fault code. The hold time and the reset delay are counters scaled by a clock-frequency parameter.

Top module: `slp_sequencer`

## Requirements
- R1: After reset the block sits in S5. Every sleep line, suspend status, platform reset and processor power-good are low, run enable is low and the fault code is 0.
- R2: A press in S5, S3 or S4 powers up to S0. Lines are released one at a time in the order S5, S4, network, management, S3, processor power-good, suspend status, platform reset. Leaving S5 waits for always-on good. Run enable is high exactly while the S3, S4, S5, management and network lines are all high.
- R3: Processor power-good rises only after run-good and memory-good are both high. If they are not, the sequence holds with run enable high and power-good low.
- R4: Platform reset rises exactly RST_US microseconds (CLK_HZ/1e6*RST_US cycles) after suspend status rises.
- R5: A press in S0 enters S3 when deep_sel is 0, or S4 when it is 1. One line is asserted per cycle, in the order platform reset, suspend status, processor power-good, S3, management, network, then S4. In S3 the S4 and S5 lines stay high.
- R6: A press in S3 or S4 returns the platform to S0.
- R7: A press that arrives while a transition is still in progress has no effect on the state that is finally reached.
- R8: Holding the button low for HOLD_MS milliseconds forces S5 from any state, including S0 and the sleep states. Fault code 3 is recorded.
- R9: Thermal trip low is ignored while processor power-good is low. While power-good is high, a low thermal trip drives all lines low on the next cycle and records fault code 2.
- R10: Loss of any rail-good input while settled in S0 starts an orderly one-line-per-cycle descent to S5 and records fault code 1.
- R11: The fault code keeps the first cause (0 none, 1 rail, 2 thermal, 3 hold) and changes only on reset.
- R12: The management line is low only while the S3 line is low. The network line is low only while the management line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_btn_n | input | 1 | Debounced power button, low while pressed |
| deep_sel | input | 1 | Sleep depth for a press in S0: 0 selects S3, 1 selects S4 |
| thermtrip_n | input | 1 | Thermal trip, low on overtemperature |
| aon_good | input | 1 | Always-on rail good |
| mgmt_good | input | 1 | Management-island rail good |
| mem_good | input | 1 | Memory rail good |
| run_good | input | 1 | Run rails good |
| slp_s3_n | output | 1 | S3 sleep line, active low |
| slp_s4_n | output | 1 | S4 sleep line, active low |
| slp_s5_n | output | 1 | S5 sleep line, active low |
| slp_mgmt_n | output | 1 | Management-island sleep line, active low |
| slp_net_n | output | 1 | Network-island sleep line, active low |
| run_en | output | 1 | Run-rail enable |
| susp_n | output | 1 | Suspend status, low while suspended |
| cpu_pwrgd | output | 1 | Processor power-good |
| plat_rst_n | output | 1 | Platform reset, active low |
| fault_code | output | 2 | Sticky first fault cause |

## Verification
The hardest situation to reach is a thermal trip while the sequencer is partway up. Run enable is already on but processor power-good is not. The stimulus reaches it by holding run-good low before the press, so that the ladder parks at that step. It then pulses thermal trip there, and confirms that the level and fault code do not move before releasing run-good. The long-hold override is driven from S3 with a shrunk clock-frequency parameter. The press that starts the hold first wakes the platform, so the bench checks that S0 is reached before the hold expires and S5 after it.

// File: rtl/slp_seq_pkg.sv
package slp_seq_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RAIL  = 2'd1,
    FLT_THERM = 2'd2,
    FLT_HOLD  = 2'd3
  } fault_e;

  // Ordered list of controlled lines; the level is the count asserted from the front
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned LVL_W     = $clog2(NUM_LINES + 1);
  typedef logic [LVL_W-1:0] lvl_t;

  localparam int unsigned IDX_RST   = 0;
  localparam int unsigned IDX_SUSP  = 1;
  localparam int unsigned IDX_PWRGD = 2;
  localparam int unsigned IDX_S3    = 3;
  localparam int unsigned IDX_MGMT  = 4;
  localparam int unsigned IDX_NET   = 5;
  localparam int unsigned IDX_S4    = 6;
  localparam int unsigned IDX_S5    = 7;

  localparam lvl_t LVL_ON    = lvl_t'(0);
  localparam lvl_t LVL_SUSP  = lvl_t'(IDX_SUSP);
  localparam lvl_t LVL_PWRGD = lvl_t'(IDX_PWRGD);
  localparam lvl_t LVL_RUN   = lvl_t'(IDX_S3);
  localparam lvl_t LVL_S3    = lvl_t'(IDX_NET + 1);
  localparam lvl_t LVL_S4    = lvl_t'(IDX_S4 + 1);
  localparam lvl_t LVL_S5    = lvl_t'(IDX_S5 + 1);

endpackage

// File: rtl/slp_dwell_timer.sv
module slp_dwell_timer #(
  parameter int unsigned LIMIT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic fire
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)            cnt_d = '0;
    else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Single pulse on the LIMIT-th consecutive enabled cycle
  assign fire = en && (cnt_q == LAST);
endmodule

// File: rtl/slp_line_decode.sv
module slp_line_decode
  import slp_seq_pkg::*;
(
  input  lvl_t                 lvl,
  output logic [NUM_LINES-1:0] asserted,
  output logic                 run_en
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign asserted[i] = (lvl > lvl_t'(i));
  end

  assign run_en = (lvl <= LVL_RUN);
endmodule

// File: rtl/slp_seq_ctrl.sv
module slp_seq_ctrl
  import slp_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   press,
  input  logic   hold_fire,
  input  logic   rst_fire,
  input  logic   deep_sel,
  input  logic   thermtrip_n,
  input  logic   aon_good,
  input  logic   mgmt_good,
  input  logic   mem_good,
  input  logic   run_good,
  output lvl_t   lvl,
  output fault_e fault
);
  lvl_t   lvl_q, lvl_d, tgt_q, tgt_d;
  fault_e flt_q, flt_d, cause;
  logic   step_ok, rails_ok, pwrgd_up;

  assign rails_ok = aon_good && mgmt_good && mem_good && run_good;
  assign pwrgd_up = (lvl_q <= LVL_PWRGD);

  always_comb begin
    unique case (lvl_q)
      LVL_S5:   step_ok = aon_good;
      LVL_RUN:  step_ok = run_good && mem_good;
      LVL_SUSP: step_ok = rst_fire;
      default:  step_ok = 1'b1;
    endcase
  end

  always_comb begin
    lvl_d = lvl_q;
    tgt_d = tgt_q;
    flt_d = flt_q;
    cause = FLT_NONE;

    if (lvl_q > tgt_q) begin
      if (step_ok) lvl_d = lvl_q - 1'b1;
    end else if (lvl_q < tgt_q) begin
      lvl_d = lvl_q + 1'b1;
    end else if (press) begin
      if (tgt_q == LVL_ON) tgt_d = deep_sel ? LVL_S4 : LVL_S3;
      else                 tgt_d = LVL_ON;
    end

    // Forced soft-off, lowest priority first
    if (lvl_q == LVL_ON && tgt_q == LVL_ON && !rails_ok) begin
      tgt_d = LVL_S5;
      cause = FLT_RAIL;
    end
    if (hold_fire) begin
      tgt_d = LVL_S5;
      cause = FLT_HOLD;
    end
    if (pwrgd_up && !thermtrip_n) begin
      tgt_d = LVL_S5;
      lvl_d = LVL_S5;
      cause = FLT_THERM;
    end

    if (flt_q == FLT_NONE && cause != FLT_NONE) flt_d = cause;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= LVL_S5;
      tgt_q <= LVL_S5;
      flt_q <= FLT_NONE;
    end else begin
      lvl_q <= lvl_d;
      tgt_q <= tgt_d;
      flt_q <= flt_d;
    end
  end

  assign lvl   = lvl_q;
  assign fault = flt_q;
endmodule

// File: rtl/slp_sequencer.sv
module slp_sequencer
  import slp_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned HOLD_MS = 4000,
  parameter int unsigned RST_US  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_btn_n,
  input  logic       deep_sel,
  input  logic       thermtrip_n,
  input  logic       aon_good,
  input  logic       mgmt_good,
  input  logic       mem_good,
  input  logic       run_good,
  output logic       slp_s3_n,
  output logic       slp_s4_n,
  output logic       slp_s5_n,
  output logic       slp_mgmt_n,
  output logic       slp_net_n,
  output logic       run_en,
  output logic       susp_n,
  output logic       cpu_pwrgd,
  output logic       plat_rst_n,
  output logic [1:0] fault_code
);
  localparam int unsigned HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
  localparam int unsigned RST_CYC  = (CLK_HZ / 1_000_000) * RST_US;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       btn_prev_q, press, hold_fire, rst_fire;
  lvl_t       lvl;
  fault_e     fault;
  logic [NUM_LINES-1:0] asserted;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) btn_prev_q <= 1'b1;
    else            btn_prev_q <= pwr_btn_n;
  end
  assign press = btn_prev_q && !pwr_btn_n;

  slp_dwell_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_int_n), .en(!pwr_btn_n), .fire(hold_fire)
  );

  slp_dwell_timer #(.LIMIT(RST_CYC)) u_rdly (
    .clk(clk), .rst_n(rst_int_n), .en(lvl == LVL_SUSP), .fire(rst_fire)
  );

  slp_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .press(press), .hold_fire(hold_fire),
    .rst_fire(rst_fire), .deep_sel(deep_sel), .thermtrip_n(thermtrip_n),
    .aon_good(aon_good), .mgmt_good(mgmt_good), .mem_good(mem_good),
    .run_good(run_good), .lvl(lvl), .fault(fault)
  );

  slp_line_decode u_dec (
    .lvl(lvl), .asserted(asserted), .run_en(run_en)
  );

  assign plat_rst_n = !asserted[IDX_RST];
  assign susp_n     = !asserted[IDX_SUSP];
  assign cpu_pwrgd  = !asserted[IDX_PWRGD];
  assign slp_s3_n   = !asserted[IDX_S3];
  assign slp_mgmt_n = !asserted[IDX_MGMT];
  assign slp_net_n  = !asserted[IDX_NET];
  assign slp_s4_n   = !asserted[IDX_S4];
  assign slp_s5_n   = !asserted[IDX_S5];
  assign fault_code = fault;
endmodule

// File: rtl/slp_sequencer_chk.sv
module slp_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       thermtrip_n,
  input logic       mem_good,
  input logic       run_good,
  input logic       slp_s3_n,
  input logic       slp_s4_n,
  input logic       slp_s5_n,
  input logic       slp_mgmt_n,
  input logic       slp_net_n,
  input logic       run_en,
  input logic       susp_n,
  input logic       cpu_pwrgd,
  input logic       plat_rst_n,
  input logic [1:0] fault_code
);
  assert_mgmt_needs_s3_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_mgmt_n |-> !slp_s3_n);

  assert_net_needs_mgmt_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !slp_net_n |-> !slp_mgmt_n);

  assert_run_en_lines_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> (slp_s3_n && slp_s4_n && slp_s5_n && slp_mgmt_n && slp_net_n));

  assert_pwrgd_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_pwrgd) |-> $past(run_good && mem_good));

  assert_rst_after_susp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    plat_rst_n |-> susp_n);

  assert_therm_kill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_pwrgd && !thermtrip_n) |=> (!slp_s5_n && !slp_s3_n && !cpu_pwrgd));

  assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != 2'd0) |=> $stable(fault_code));
endmodule

bind slp_sequencer slp_sequencer_chk u_chk (.*);

// File: tb/slp_sequencer_test.sv
`timescale 1ns/1ps
module slp_sequencer_test;
  localparam int CLK_HZ   = 1_000_000;
  localparam int HOLD_MS  = 1;
  localparam int RST_US   = 60;
  localparam int HOLD_CYC = (CLK_HZ / 1000) * HOLD_MS;
  localparam int RST_CYC  = (CLK_HZ / 1_000_000) * RST_US;

  logic clk = 1'b0;
  logic rst_n, pwr_btn_n, deep_sel, thermtrip_n;
  logic aon_good, mgmt_good, mem_good, run_good;
  logic slp_s3_n, slp_s4_n, slp_s5_n, slp_mgmt_n, slp_net_n;
  logic run_en, susp_n, cpu_pwrgd, plat_rst_n;
  logic [1:0] fault_code;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  slp_sequencer #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS), .RST_US(RST_US)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_btn_n(pwr_btn_n), .deep_sel(deep_sel),
    .thermtrip_n(thermtrip_n), .aon_good(aon_good), .mgmt_good(mgmt_good),
    .mem_good(mem_good), .run_good(run_good), .slp_s3_n(slp_s3_n),
    .slp_s4_n(slp_s4_n), .slp_s5_n(slp_s5_n), .slp_mgmt_n(slp_mgmt_n),
    .slp_net_n(slp_net_n), .run_en(run_en), .susp_n(susp_n),
    .cpu_pwrgd(cpu_pwrgd), .plat_rst_n(plat_rst_n), .fault_code(fault_code)
  );

  // Count of asserted lines in the order rst, susp, pwrgd, s3, mgmt, net, s4, s5; -1 if not a prefix
  function automatic int lvl_of();
    logic [7:0] a;
    int n;
    a = {!slp_s5_n, !slp_s4_n, !slp_net_n, !slp_mgmt_n, !slp_s3_n, !cpu_pwrgd, !susp_n, !plat_rst_n};
    n = 0;
    while (n < 8 && a[n]) n++;
    for (int i = n; i < 8; i++) if (a[i]) return -1;
    return n;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pwr_btn_n = 1'b1; deep_sel = 1'b0; thermtrip_n = 1'b1;
    aon_good = 1'b1; mgmt_good = 1'b1; mem_good = 1'b1; run_good = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic press_btn();
    @(negedge clk) pwr_btn_n = 1'b0;
    @(negedge clk) pwr_btn_n = 1'b1;
  endtask

  // Follow the level per cycle; down: exactly +1 per cycle, up: 0 or -1 per cycle
  task automatic track(input int goal, input bit down, input int maxc,
                       output bit ok, output int dly);
    int prev, l, t1;
    ok = 1'b1; dly = -1; t1 = -1; prev = lvl_of();
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      l = lvl_of();
      if (l < 0) ok = 1'b0;
      else if (down && l != prev + 1) ok = 1'b0;
      else if (!down && l != prev && l != prev - 1) ok = 1'b0;
      if (run_en !== (l >= 0 && l <= 3)) ok = 1'b0;
      if (l == 1 && t1 < 0) t1 = c;
      if (l == 0 && t1 >= 0 && dly < 0) dly = c - t1;
      prev = l;
      if (l == goal) break;
    end
    if (prev != goal) ok = 1'b0;
  endtask

  task automatic power_up();
    bit ok; int dly;
    press_btn();
    track(0, 1'b0, 200, ok, dly);
  endtask

  task automatic t_reset();
    do_reset();
    chk(lvl_of() == 8, "R1 all lines low after reset", lvl_of(), 8);
    chk(run_en == 1'b0 && fault_code == 2'd0, "R1 run_en/fault after reset",
        {run_en, fault_code}, 0);
  endtask

  task automatic t_power_up();
    bit ok; int dly;
    do_reset();
    run_good = 1'b0;
    press_btn();
    track(3, 1'b0, 40, ok, dly);
    chk(ok, "R2 ordered release down to run step", lvl_of(), 3);
    repeat (10) @(negedge clk);
    chk(lvl_of() == 3 && run_en && !cpu_pwrgd, "R3 power-good waits for run_good",
        lvl_of(), 3);
    thermtrip_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(lvl_of() == 3 && fault_code == 2'd0, "R9 thermal ignored before power-good",
        fault_code, 0);
    thermtrip_n = 1'b1;
    run_good = 1'b1;
    track(0, 1'b0, 200, ok, dly);
    chk(ok, "R2 ordered release reaches S0", lvl_of(), 0);
    chk(dly == RST_CYC, "R4 reset delay after suspend status", dly, RST_CYC);
  endtask

  task automatic t_sleep(input bit deep);
    bit ok; int dly; int goal;
    goal = deep ? 7 : 6;
    deep_sel = deep;
    press_btn();
    track(goal, 1'b1, 20, ok, dly);
    chk(ok, deep ? "R5 ordered entry to S4" : "R5 ordered entry to S3", lvl_of(), goal);
    repeat (5) @(negedge clk);
    chk(slp_s5_n && (slp_s4_n == !deep), "R5 S4/S5 lines in sleep", {slp_s4_n, slp_s5_n}, deep ? 1 : 3);
    press_btn();
    track(0, 1'b0, 200, ok, dly);
    chk(ok && lvl_of() == 0, "R6 wake to S0", lvl_of(), 0);
    deep_sel = 1'b0;
  endtask

  task automatic t_transit();
    @(negedge clk) pwr_btn_n = 1'b0;
    @(negedge clk) pwr_btn_n = 1'b1;
    @(negedge clk) pwr_btn_n = 1'b0;
    @(negedge clk) pwr_btn_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(lvl_of() == 6, "R7 press during descent ignored", lvl_of(), 6);
  endtask

  task automatic t_hold();
    @(negedge clk) pwr_btn_n = 1'b0;
    repeat (HOLD_CYC - 20) @(negedge clk);
    chk(lvl_of() == 0, "R8 not off before hold time", lvl_of(), 0);
    repeat (25) @(negedge clk);
    pwr_btn_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(lvl_of() == 8, "R8 hold forces S5", lvl_of(), 8);
    chk(fault_code == 2'd3, "R8 hold fault code", fault_code, 3);
  endtask

  task automatic t_thermal();
    do_reset();
    power_up();
    @(negedge clk) thermtrip_n = 1'b0;
    @(negedge clk);
    chk(lvl_of() == 8, "R9 thermal trip drops all lines next cycle", lvl_of(), 8);
    chk(fault_code == 2'd2, "R9 thermal fault code", fault_code, 2);
    thermtrip_n = 1'b1;
    power_up();
    @(negedge clk) pwr_btn_n = 1'b0;
    repeat (HOLD_CYC + 10) @(negedge clk);
    pwr_btn_n = 1'b1;
    repeat (20) @(negedge clk);
    chk(lvl_of() == 8 && fault_code == 2'd2, "R11 first fault cause kept", fault_code, 2);
  endtask

  task automatic t_rail();
    bit ok; int dly;
    do_reset();
    power_up();
    @(negedge clk) mem_good = 1'b0;
    @(negedge clk);
    track(8, 1'b1, 20, ok, dly);
    chk(ok, "R10 orderly descent on rail loss", lvl_of(), 8);
    chk(fault_code == 2'd1, "R10 rail fault code", fault_code, 1);
    mem_good = 1'b1;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_power_up();
    t_sleep(1'b0);
    t_sleep(1'b1);
    t_transit();
    t_hold();
    t_thermal();
    t_rail();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule